// File: doc/BRIEF.md
# Per-Thread Squash Arbiter

This block sits in the retire stage of an out-of-order core. Each hardware thread has one instance of it. It decides which squash request wins in a cycle. The candidates are a trap squash, a squash requested on behalf of the thread context, and a squash reported by the execute stage. For the winner it produces the sequence-number boundary: reorder-buffer entries younger than the boundary are to be discarded. It also tracks the thread's retire status, which is running, squashing or waiting on a trap.

The block keeps the youngest sequence number the thread has inserted into the reorder buffer. It uses that number to reject an execute-stage squash that is younger than a squash already applied. While the thread is squashing or has a trap pending, the block blocks insertion of renamed instructions. It also tells the earlier stages when the reorder buffer has fully drained. That indication is raised only once no store is left in flight.

Top module: `squash_arbiter`

## Requirements
- R1: A trap squash or a thread-context squash discards the whole thread. It raises `sq_fire`, and `sq_bound` is `rob_head_seq - 1`, or 0 when `rob_empty` is high. The youngest tracked sequence number becomes 0.
- R2: An execute squash is taken only if the thread is not in trap-pending status (`status` = 2). The request must also satisfy `exe_sq_seq` ≤ the youngest tracked sequence number. Otherwise it produces no `sq_fire`.
- R3: For a taken execute squash, `sq_bound` is `exe_sq_seq - 1` when `exe_sq_incl` is high and `exe_sq_seq` otherwise. The youngest tracked sequence number becomes that boundary.
- R4: Any squash sets `status` to squashing (1) on the next cycle. While squashing, `rob_squashing` is high in every cycle in which `rob_sq_done` is low. In the cycle `rob_sq_done` is high, `rob_squashing` is low, and `status` returns to running (0) on the next cycle.
- R5: `ins_en` is low while squashing without `rob_sq_done`, in trap-pending status, in a cycle that raises `sq_fire`, and for an instruction with `ins_squashed` high. Otherwise it follows `ins_req`.
- R6: Each insertion sets the youngest tracked sequence number to `ins_seq`. After reset that number is all ones.
- R7: `empty_bcast` requires `rob_empty` high, `stores_pending` low and `store_committed` low. It is high once after reset and once after each time the buffer held entries or a squash fired, then drops until re-armed.
- R8: `trap_arm` in running status moves `status` to trap-pending and marks a trap in flight. A trap squash clears the in-flight mark. A trap squash wins over a thread-context squash in the same cycle.
- R9: A thread-context squash request while a trap is in flight raises `tc_err` and is not serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_arm | input | 1 | A trap has been raised for this thread |
| trap_sq_req | input | 1 | Trap squash is due this cycle |
| tc_sq_req | input | 1 | Thread-context squash request |
| exe_sq_valid | input | 1 | Execute-stage squash request |
| exe_sq_seq | input | SEQ_W | Sequence number of the squashing instruction |
| exe_sq_incl | input | 1 | The squashing instruction is discarded too |
| rob_head_seq | input | SEQ_W | Sequence number at the buffer head |
| rob_empty | input | 1 | Buffer holds no entry for this thread |
| rob_sq_done | input | 1 | Buffer has finished its squash walk |
| ins_req | input | 1 | Renamed instruction offered for insertion |
| ins_seq | input | SEQ_W | Its sequence number |
| ins_squashed | input | 1 | The offered instruction is already squashed |
| stores_pending | input | 1 | Stores still wait for writeback |
| store_committed | input | 1 | A store retired in this cycle |
| sq_fire | output | 1 | A squash is issued this cycle |
| sq_bound | output | SEQ_W | Squash boundary sequence number |
| rob_squashing | output | 1 | Buffer squash in progress |
| status | output | 2 | 0 running, 1 squashing, 2 trap pending |
| ins_en | output | 1 | Insert the offered instruction |
| empty_bcast | output | 1 | Buffer drained, tell earlier stages |
| tc_err | output | 1 | Thread-context squash collided with a trap in flight |

## Verification
The execute-squash decision is tried against a table. Each row pairs a youngest inserted number with a squash number and include flag. The rows are chosen to separate the cases below the youngest, equal to it and above it, with and without the include flag. A comparison of the wrong strictness or a missing decrement shows up as a wrong acceptance or a wrong boundary. Directed sequences then feed overlapping trap, thread-context and execute requests, and one of them applies a squash that reorders the youngest number. These separate the priority order, the trap-pending block and the boundary rewrite. The insertion gate and the store-qualified empty broadcast are each driven with one blocking condition at a time.

// File: rtl/squash_arbiter.sv
module squash_arbiter #(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_arm,
  input  logic             trap_sq_req,
  input  logic             tc_sq_req,
  input  logic             exe_sq_valid,
  input  logic [SEQ_W-1:0] exe_sq_seq,
  input  logic             exe_sq_incl,
  input  logic [SEQ_W-1:0] rob_head_seq,
  input  logic             rob_empty,
  input  logic             rob_sq_done,
  input  logic             ins_req,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic             ins_squashed,
  input  logic             stores_pending,
  input  logic             store_committed,
  output logic             sq_fire,
  output logic [SEQ_W-1:0] sq_bound,
  output logic             rob_squashing,
  output logic [1:0]       status,
  output logic             ins_en,
  output logic             empty_bcast,
  output logic             tc_err
);
  localparam logic [1:0] ST_RUN  = 2'd0;
  localparam logic [1:0] ST_SQ   = 2'd1;
  localparam logic [1:0] ST_TRAP = 2'd2;

  logic [1:0]       status_q;
  logic [SEQ_W-1:0] young_q;
  logic             inflight_q;
  logic             arm_q;

  logic             trap_take, tc_take, all_take, exe_take, sq_done_now, arm_trap;
  logic [1:0]       eff_status;
  logic [SEQ_W-1:0] eff_young, all_bound, exe_bound;

  assign trap_take  = trap_sq_req;
  assign tc_take    = tc_sq_req && !trap_sq_req && !inflight_q;
  assign all_take   = trap_take || tc_take;
  assign all_bound  = rob_empty ? '0 : rob_head_seq - 1'b1;

  assign eff_status = all_take ? ST_SQ : status_q;
  assign eff_young  = all_take ? '0 : young_q;
  assign exe_take   = exe_sq_valid && (eff_status != ST_TRAP) && (exe_sq_seq <= eff_young);
  assign exe_bound  = exe_sq_incl ? exe_sq_seq - 1'b1 : exe_sq_seq;

  assign sq_fire     = all_take || exe_take;
  assign sq_bound    = exe_take ? exe_bound : all_bound;
  assign sq_done_now = (status_q == ST_SQ) && rob_sq_done;
  assign arm_trap    = trap_arm && (status_q == ST_RUN) && !sq_fire;

  assign rob_squashing = sq_fire || ((status_q == ST_SQ) && !rob_sq_done);
  assign ins_en        = ins_req && !ins_squashed && !sq_fire &&
                         ((status_q == ST_RUN) || sq_done_now);
  assign empty_bcast   = arm_q && rob_empty && !stores_pending && !store_committed;
  assign tc_err        = tc_sq_req && inflight_q;
  assign status        = status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q   <= ST_RUN;
      young_q    <= '1;
      inflight_q <= 1'b0;
      arm_q      <= 1'b1;
    end else begin
      if (sq_fire)          status_q <= ST_SQ;
      else if (sq_done_now) status_q <= ST_RUN;
      else if (arm_trap)    status_q <= ST_TRAP;

      if (trap_take)        inflight_q <= 1'b0;
      else if (arm_trap)    inflight_q <= 1'b1;

      if (sq_fire)          young_q <= exe_take ? exe_bound : '0;
      else if (ins_en)      young_q <= ins_seq;

      if (empty_bcast)      arm_q <= 1'b0;
      else if (sq_fire || !rob_empty) arm_q <= 1'b1;
    end
  end

  AST_SQ_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    sq_fire |=> status == ST_SQ);  // R4
  AST_SQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_SQ && !rob_sq_done) |-> rob_squashing);  // R4
  AST_NO_INS_SQUASHING: assert property (@(posedge clk) disable iff (!rst_n)
    (status != ST_RUN && !rob_sq_done) |-> !ins_en);  // R5
  AST_NO_INS_SQUASHED: assert property (@(posedge clk) disable iff (!rst_n)
    ins_squashed |-> !ins_en);  // R5
  AST_YOUNG_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |=> young_q == $past(ins_seq));  // R6
  AST_EMPTY_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    empty_bcast |-> (rob_empty && !stores_pending && !store_committed));  // R7
  AST_TRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    trap_sq_req |=> !inflight_q);  // R8
  AST_TRAP_BLOCKS_EXE: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_TRAP && !trap_sq_req && !tc_sq_req) |-> !sq_fire);  // R2
endmodule

// File: tb/squash_arbiter_bench.sv
module squash_arbiter_bench;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst_n;
  logic trap_arm, trap_sq_req, tc_sq_req, exe_sq_valid, exe_sq_incl;
  logic [W-1:0] exe_sq_seq, rob_head_seq, ins_seq;
  logic rob_empty, rob_sq_done, ins_req, ins_squashed, stores_pending, store_committed;
  logic sq_fire, rob_squashing, ins_en, empty_bcast, tc_err;
  logic [W-1:0] sq_bound;
  logic [1:0] status;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  squash_arbiter #(.SEQ_W(W)) u_squash_arbiter (
    .clk(clk), .rst_n(rst_n), .trap_arm(trap_arm), .trap_sq_req(trap_sq_req),
    .tc_sq_req(tc_sq_req), .exe_sq_valid(exe_sq_valid), .exe_sq_seq(exe_sq_seq),
    .exe_sq_incl(exe_sq_incl), .rob_head_seq(rob_head_seq), .rob_empty(rob_empty),
    .rob_sq_done(rob_sq_done), .ins_req(ins_req), .ins_seq(ins_seq),
    .ins_squashed(ins_squashed), .stores_pending(stores_pending),
    .store_committed(store_committed), .sq_fire(sq_fire), .sq_bound(sq_bound),
    .rob_squashing(rob_squashing), .status(status), .ins_en(ins_en),
    .empty_bcast(empty_bcast), .tc_err(tc_err));

  // young, seq, incl, fire, bound
  localparam logic [49:0] VEC [6] = '{
    {16'd100, 16'd50,  1'b0, 1'b1, 16'd50},
    {16'd100, 16'd100, 1'b0, 1'b1, 16'd100},
    {16'd100, 16'd101, 1'b0, 1'b0, 16'd0},
    {16'd100, 16'd100, 1'b1, 1'b1, 16'd99},
    {16'd7,   16'd1,   1'b1, 1'b1, 16'd0},
    {16'd7,   16'd200, 1'b1, 1'b0, 16'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    trap_arm = 0; trap_sq_req = 0; tc_sq_req = 0; exe_sq_valid = 0;
    exe_sq_seq = '0; exe_sq_incl = 0; rob_head_seq = '0; rob_empty = 1;
    rob_sq_done = 0; ins_req = 0; ins_seq = '0; ins_squashed = 0;
    stores_pending = 0; store_committed = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    idle(); rst_n = 0; tick(); tick(); rst_n = 1;
  endtask

  task automatic finish_squash();
    idle(); rob_sq_done = 1; tick(); idle();
  endtask

  task automatic exe(input logic [W-1:0] s, input logic incl);
    exe_sq_valid = 1; exe_sq_seq = s; exe_sq_incl = incl; #3;
  endtask

  initial begin
    #2000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset(); #3;
    chk("R4 reset status", status, 0);
    chk("R4 reset rob_squashing", rob_squashing, 0);
    chk("R7 reset empty_bcast", empty_bcast, 1);

    for (int i = 0; i < 6; i++) begin
      do_reset();
      ins_req = 1; ins_seq = VEC[i][49:34]; tick(); idle();
      exe(VEC[i][33:18], VEC[i][17]);
      chk("R2 table fire", sq_fire, VEC[i][16]);
      if (VEC[i][16]) chk("R3 table bound", sq_bound, VEC[i][15:0]);
      tick(); idle();
    end

    do_reset();
    exe(16'hFFFF, 0);
    chk("R6 reset youngest all ones", sq_fire, 1);
    tick(); idle(); #3;
    chk("R4 squashing status", status, 1);
    chk("R4 rob_squashing held", rob_squashing, 1);
    ins_req = 1; ins_seq = 5; #1;
    chk("R5 no insert while squashing", ins_en, 0);
    tick(); #3;
    chk("R4 still squashing", status, 1);
    rob_sq_done = 1; #1;
    chk("R4 done drops rob_squashing", rob_squashing, 0);
    chk("R5 insert on done cycle", ins_en, 1);
    tick(); idle(); #3;
    chk("R4 back to running", status, 0);

    ins_req = 1; ins_seq = 40; ins_squashed = 1; #1;
    chk("R5 squashed not inserted", ins_en, 0);
    ins_squashed = 0; #1;
    chk("R5 insert running", ins_en, 1);
    tick(); idle();
    exe(41, 0);
    chk("R6 above youngest rejected", sq_fire, 0);
    exe(40, 0);
    chk("R6 equal youngest taken", sq_fire, 1);
    chk("R3 bound no incl", sq_bound, 40);
    tick(); finish_squash();

    exe(40, 1);
    chk("R3 bound incl", sq_bound, 39);
    tick(); finish_squash();
    exe(40, 0);
    chk("R3 youngest rewritten reject", sq_fire, 0);
    exe(39, 0);
    chk("R3 youngest rewritten accept", sq_fire, 1);
    tick(); finish_squash();

    rob_empty = 0; rob_head_seq = 10; trap_sq_req = 1; #3;
    chk("R1 trap fire", sq_fire, 1);
    chk("R1 trap bound head-1", sq_bound, 9);
    tick(); finish_squash();
    tc_sq_req = 1; #3;
    chk("R1 tc fire", sq_fire, 1);
    chk("R1 tc bound empty", sq_bound, 0);
    tick(); finish_squash();

    trap_arm = 1; tick(); idle(); #3;
    chk("R8 trap pending status", status, 2);
    exe(0, 0);
    chk("R2 trap pending blocks exe", sq_fire, 0);
    idle(); ins_req = 1; ins_seq = 3; #1;
    chk("R5 no insert trap pending", ins_en, 0);
    idle(); tc_sq_req = 1; #1;
    chk("R9 tc_err raised", tc_err, 1);
    chk("R9 tc not serviced", sq_fire, 0);
    trap_sq_req = 1; #1;
    chk("R8 trap wins fire", sq_fire, 1);
    tick(); idle(); #3;
    chk("R8 trap squash status", status, 1);
    tc_sq_req = 1; #1;
    chk("R8 in-flight cleared", tc_err, 0);
    chk("R8 tc serviced after trap", sq_fire, 1);
    tick(); finish_squash();

    rob_empty = 0; tick();
    rob_empty = 1; stores_pending = 1; #1;
    chk("R7 stores pending blocks", empty_bcast, 0);
    tick(); stores_pending = 0; store_committed = 1; #1;
    chk("R7 store committed blocks", empty_bcast, 0);
    tick(); store_committed = 0; #1;
    chk("R7 broadcast", empty_bcast, 1);
    tick(); #1;
    chk("R7 one shot", empty_bcast, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule